// File: doc/BRIEF.md
# Three-Slot Instruction Decode Grouper

This block sits between an in-order queue of pre-classified instruction descriptors and three decode slots, named d0, d1 and d2. Each descriptor carries only a micro-op count and a byte length. Every cycle the grouper looks at the oldest queued entries and decides how many of them decode together. Only the first slot, d0, takes an instruction of several micro-ops. The two side slots take only single-micro-op instructions of short length. A group ends at the first instruction that fails a side-slot test, and that instruction opens the next group in d0.

An instruction needing more micro-ops than d0 can take is decoded alone. It holds d0 over as many cycles as needed and emits at most six micro-ops per cycle. The per-cycle record gives three things: how many instructions finished, which slots are occupied, and how many micro-ops came out. A testbench or a downstream model can check that record directly. Descriptors enter through a valid/ready handshake into a small circular queue. An entry leaves the queue only in the cycle its decode completes.

Top module: `uop_group_decoder`

## Requirements
- R1: After reset, and whenever the queue is empty, the group is zero: grp_count=0, grp_mask=0, grp_uops=0. Reset also clears any multi-cycle decode in progress. in_ready is 1 when the queue is empty.
- R2: The oldest queued instruction always occupies d0 when its micro-op count is 1 to 4. When the next entry does not qualify for d1, the group is that instruction alone: grp_count=1, grp_mask=3'b001, grp_uops equal to its count.
- R3: An entry qualifies for a side slot only if it has exactly 1 micro-op and a length of at most 7 bytes. d1 takes the second-oldest entry if that entry qualifies. d2 takes the third-oldest entry only if d1 is filled and the third entry qualifies. grp_uops is the d0 count plus one per filled side slot.
- R4: An instruction that ends a group early is not dropped or reordered. It occupies d0 in the following cycle.
- R5: An instruction of more than 4 micro-ops is decoded alone, with grp_mask=3'b001 in every cycle it occupies. Each cycle it emits the smaller of its remaining count and 6. grp_count is 0 on its non-final cycles and 1 on its final cycle.
- R6: grp_uops never exceeds 6 in any cycle.
- R7: For the counts 1,1,2,1,1,1,8 (all of length 3), fed while the queue is kept supplied, the non-empty groups are {1,1}, then {2,1,1}, then {1}, then the 8-op instruction alone for two cycles emitting 6 and then 2.
- R8: in_ready is 0 exactly when the queue holds DEPTH entries. A descriptor is accepted on a rising edge with in_valid and in_ready both high. Accepted descriptors decode in acceptance order.
- R9: grp_mask bit 0 marks d0, bit 1 marks d1, bit 2 marks d2. grp_count is the number of instructions whose decode completes this cycle, from 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor offered |
| in_uops | input | UW (5) | Micro-op count of offered descriptor, 1 or more |
| in_len | input | LW (4) | Byte length of offered descriptor |
| in_ready | output | 1 | Queue has room |
| grp_count | output | 2 | Instructions completed this cycle |
| grp_mask | output | 3 | Occupied slots, bit 0 = d0 |
| grp_uops | output | UW (5) | Micro-ops emitted this cycle |

## Verification
The group record is combinational from the registered queue and continuation state. A descriptor accepted on a rising edge is therefore first seen in the record during the cycle after that edge. A multi-cycle instruction moves on by one slice at each edge. The bench keeps its own model of the queue and evaluates the expected record at every falling edge, before it drives the next input. It then advances that model exactly as the coming rising edge will, applying the pop and any accepted push. For the fixed example sequence, the bench records every non-empty group and compares the ordered list, so idle cycles cannot shift the result.

// File: rtl/uop_group_decoder.sv
module uop_group_decoder #(
  parameter int DEPTH          = 8,
  parameter int UW             = 5,
  parameter int LW             = 4,
  parameter int D0_MAX_UOPS    = 4,
  parameter int SIDE_MAX_LEN   = 7,
  parameter int CYCLE_MAX_UOPS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [UW-1:0] in_uops,
  input  logic [LW-1:0] in_len,
  output logic          in_ready,
  output logic [1:0]    grp_count,
  output logic [2:0]    grp_mask,
  output logic [UW-1:0] grp_uops
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [UW-1:0] D0_LIM  = UW'(D0_MAX_UOPS);
  localparam logic [UW-1:0] CYC_LIM = UW'(CYCLE_MAX_UOPS);
  localparam logic [LW-1:0] LEN_LIM = LW'(SIDE_MAX_LEN);
  localparam logic [UW-1:0] ONE     = UW'(1);

  logic [UW-1:0] q_uops [DEPTH];
  logic [LW-1:0] q_len  [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] occ;
  logic          mc_busy;
  logic [UW-1:0] mc_rem;

  wire [AW-1:0] p1 = rd_ptr + AW'(1);
  wire [AW-1:0] p2 = rd_ptr + AW'(2);

  wire [UW-1:0] u0 = q_uops[rd_ptr];
  wire [UW-1:0] u1 = q_uops[p1];
  wire [UW-1:0] u2 = q_uops[p2];
  wire [LW-1:0] l1 = q_len[p1];
  wire [LW-1:0] l2 = q_len[p2];

  wire have0 = occ != '0;
  wire have1 = occ > CW'(1);
  wire have2 = occ > CW'(2);

  wire          big   = have0 && (mc_busy || u0 > D0_LIM);
  wire [UW-1:0] rem   = mc_busy ? mc_rem : u0;
  wire          last  = rem <= CYC_LIM;
  wire          ok1   = (u1 == ONE) && (l1 <= LEN_LIM);
  wire          ok2   = (u2 == ONE) && (l2 <= LEN_LIM);
  wire          take1 = have0 && !big && have1 && ok1;
  wire          take2 = take1 && have2 && ok2;
  wire          push  = in_valid && in_ready;

  logic [1:0]    cnt;
  logic [UW-1:0] uops_out;

  always_comb begin
    cnt      = 2'd0;
    uops_out = '0;
    if (big) begin
      cnt      = last ? 2'd1 : 2'd0;
      uops_out = last ? rem : CYC_LIM;
    end else if (have0) begin
      cnt      = 2'd1 + {1'b0, take1} + {1'b0, take2};
      uops_out = u0 + UW'(take1) + UW'(take2);
    end
  end

  assign in_ready  = occ != CW'(DEPTH);
  assign grp_count = cnt;
  assign grp_mask  = {take2, take1, have0};
  assign grp_uops  = uops_out;

  always_ff @(posedge clk) begin
    if (push) begin
      q_uops[wr_ptr] <= in_uops;
      q_len[wr_ptr]  <= in_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      occ     <= '0;
      mc_busy <= 1'b0;
      mc_rem  <= '0;
    end else begin
      rd_ptr <= rd_ptr + AW'(cnt);
      if (push) wr_ptr <= wr_ptr + AW'(1);
      occ <= occ + CW'(push) - CW'(cnt);
      if (big && !last) begin
        mc_busy <= 1'b1;
        mc_rem  <= rem - CYC_LIM;
      end else if (big) begin
        mc_busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uop_group_decoder_chk.sv
module uop_group_decoder_chk #(
  parameter int UW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    grp_count,
  input logic [2:0]    grp_mask,
  input logic [UW-1:0] grp_uops
);
  // R6
  uops_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_uops <= UW'(6));

  // R9
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_mask == 3'b000 || grp_mask == 3'b001 || grp_mask == 3'b011 || grp_mask == 3'b111);

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_mask == 3'b000 |-> grp_count == 2'd0 && grp_uops == '0);

  // R5
  partial_six_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_mask == 3'b001 && grp_count == 2'd0 |-> grp_uops == UW'(6));

  // R5
  cont_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_mask == 3'b001 && grp_count == 2'd0 |=> grp_mask == 3'b001);

  // R3
  side_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_mask[1] |-> int'(grp_count) == $countones(grp_mask));
endmodule

bind uop_group_decoder uop_group_decoder_chk #(.UW(UW)) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_count(grp_count), .grp_mask(grp_mask), .grp_uops(grp_uops)
);

// File: tb/uop_group_decoder_bench.sv
`timescale 1ns/100ps
module uop_group_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [4:0] in_uops = '0;
  logic [3:0] in_len = '0;
  logic       in_ready;
  logic [1:0] grp_count;
  logic [2:0] grp_mask;
  logic [4:0] grp_uops;

  uop_group_decoder u_uop_group_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops), .in_len(in_len),
    .in_ready(in_ready), .grp_count(grp_count), .grp_mask(grp_mask), .grp_uops(grp_uops)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int mu [0:4095];
  int ml [0:4095];
  int mh = 0, mt = 0, mrem = 0;
  bit mbusy = 0;
  bit recording = 0;
  int rec_n = 0;
  int rec_mask [0:31];
  int rec_uops [0:31];
  int rec_cnt  [0:31];
  int lfsr = 32'h1d2c;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  task automatic step(input bit drv, input int u, input int l, output bit acc);
    int occ, ecnt, emask, euops, rem;
    bit big, t1, t2;
    string tag;
    occ = mt - mh;
    ecnt = 0; emask = 0; euops = 0; big = 0; t1 = 0; t2 = 0; rem = 0;
    if (occ > 0) begin
      big = mbusy || mu[mh] > 4;
      if (big) begin
        rem = mbusy ? mrem : mu[mh];
        emask = 1;
        ecnt = (rem <= 6) ? 1 : 0;
        euops = (rem <= 6) ? rem : 6;
      end else begin
        t1 = occ > 1 && mu[mh+1] == 1 && ml[mh+1] <= 7;
        t2 = t1 && occ > 2 && mu[mh+2] == 1 && ml[mh+2] <= 7;
        ecnt = 1 + int'(t1) + int'(t2);
        emask = 1 + 2*int'(t1) + 4*int'(t2);
        euops = mu[mh] + int'(t1) + int'(t2);
      end
    end
    tag = (occ == 0) ? "R1" : big ? "R5" : (t1 ? "R3" : "R2");
    chk({tag, " count"}, int'(grp_count), ecnt);
    chk({tag, " R9 mask"}, int'(grp_mask), emask);
    chk({tag, " uops"}, int'(grp_uops), euops);
    chk("R6 cap", int'(grp_uops <= 5'd6), 1);
    chk("R8 ready", int'(in_ready), int'(occ < 8));
    if (recording && grp_mask != 0 && rec_n < 32) begin
      rec_mask[rec_n] = int'(grp_mask);
      rec_uops[rec_n] = int'(grp_uops);
      rec_cnt[rec_n]  = int'(grp_count);
      rec_n++;
    end
    in_valid = drv;
    in_uops  = 5'(u);
    in_len   = 4'(l);
    acc = drv && occ < 8;
    mh += ecnt;
    if (big) begin
      if (rem > 6) begin mbusy = 1; mrem = rem - 6; end
      else mbusy = 0;
    end
    if (acc) begin mu[mt] = u; ml[mt] = l; mt++; end
    @(negedge clk);
  endtask

  task automatic send(input int u, input int l);
    bit acc;
    acc = 0;
    while (!acc) step(1, u, l, acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(0, 0, 0, acc);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mh = 0; mt = 0; mbusy = 0; mrem = 0;
    in_valid = 1'b0;
    #1;
    chk("R1 reset count", int'(grp_count), 0);
    chk("R1 reset mask", int'(grp_mask), 0);
    chk("R1 reset uops", int'(grp_uops), 0);
    chk("R1 reset ready", int'(in_ready), 1);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int u, l;
    int eu [0:9];
    int em [0:9];
    int ec [0:9];
    @(negedge clk);
    do_reset();
    idle(3);

    // R7 / R4 example sequence behind a 30-op instruction that fills the queue
    recording = 1;
    send(30, 5);
    send(1, 3); send(1, 3); send(2, 3); send(1, 3); send(1, 3); send(1, 3); send(8, 3);
    idle(8);
    recording = 0;
    em = '{1, 1, 1, 1, 1, 3, 7, 1, 1, 1};
    eu = '{6, 6, 6, 6, 6, 2, 4, 1, 6, 2};
    ec = '{0, 0, 0, 0, 1, 2, 3, 1, 0, 1};
    chk("R7 group total", rec_n, 10);
    for (int i = 0; i < 10; i++) begin
      chk("R7 mask", rec_mask[i], em[i]);
      chk("R7 uops", rec_uops[i], eu[i]);
      chk("R4 count", rec_cnt[i], ec[i]);
    end

    // sweep every micro-op count in d0, followed by side candidates at the length boundary
    for (int k = 1; k < 32; k++) begin
      send(k, 2);
      send(1, 7);
      send(1, 7);
      send(1, 8);
      send(1, 1);
    end
    idle(10);

    // pseudo-random stream with gaps and full-queue pressure
    for (int n = 0; n < 1500; n++) begin
      lfsr = lfsr ^ (lfsr << 7);
      lfsr = lfsr ^ (lfsr >> 9);
      lfsr = lfsr ^ (lfsr << 8);
      case (lfsr & 7)
        5: u = 1 + ((lfsr >> 3) & 3);
        6: u = 5 + ((lfsr >> 5) & 7);
        7: u = 1 + ((lfsr >> 8) % 31);
        default: u = 1;
      endcase
      l = 1 + ((lfsr >> 13) % 15);
      send(u, l);
      if (((lfsr >> 20) & 15) == 0) idle(2);
    end
    idle(60);

    // R1 reset in the middle of a multi-cycle decode
    send(31, 4);
    send(1, 2);
    idle(2);
    do_reset();
    idle(3);
    chk("R1 post reset mask", int'(grp_mask), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule